// File: doc/BRIEF.md
# Training Pattern Presentation Sequencer

This controller walks a learning network through one training pattern at a time. A pattern comes in over a valid/ready handshake. The controller captures it and drives it on a held output for the whole presentation. Over a fixed frame of five clock subphases per phase it raises the control strobes the network needs: a noise burst that heats and then freezes the neurons, a strobe that tells every synapse to count correlations, and a strobe that commits the weight update. A phase-select line tells the synapses whether the current phase is the clamped (teacher) or free-running (student) one. A clamp line tells the output neurons whether to follow the supplied pattern.

The mode is sampled when a pattern is accepted and sets the shape of the presentation:
- Supervised learning runs a teacher phase and then a student phase.
- Test presents a single free-running phase with no learning.
- Unsupervised learning runs two phases that both report teacher.
- Weight loading uses a single phase to shift stored weights into the synapses.

In unsupervised learning a programmable counter raises a decay pulse once every N presentations.

The handshake has these rules. `pat_ready` is high only while the sequencer is idle. A pattern is taken on a clock edge where `pat_valid` and `pat_ready` are both high. Because no pattern is accepted while busy, the source must hold `pat_valid` and its data until the sequencer is idle again. The held pattern and the strobes are plain level outputs with no back-pressure, because the network consumes them every cycle.

Top module: `present_seq`

## Requirements
- R1: `pat_ready` is 1 exactly when the sequencer is idle. A pattern is accepted on an edge with `pat_valid`=1 and `pat_ready`=1. From the next cycle `pat_hold` shows that pattern and stays unchanged through the whole presentation. `pat_valid`, `pat_data` and `mode` are ignored while busy.
- R2: The mode input is sampled at acceptance: 0 is supervised, 1 is test, 2 is unsupervised and 3 is weight load. Every phase lasts five cycles. Modes 0 and 2 run two phases (ten cycles), and modes 1 and 3 run one phase (five cycles). `done` is 1 only on the last cycle of a presentation, and `pat_ready` returns to 1 on the following cycle.
- R3: `noise_en` is 1 only in the first cycle of each phase, and never in mode 3.
- R4: `corr_strobe` is 1 only in the second cycle of each phase, and only in modes 0 and 2.
- R5: `adjust_strobe` is 1 only in the fourth cycle of the second phase, in modes 0 and 2. It is never 1 in modes 1 and 3. In the third and fifth cycles of any phase, none of `noise_en`, `corr_strobe` or `adjust_strobe` is 1.
- R6: In mode 0, `phase_teacher` and `clamp_out` are 1 throughout the first phase and 0 throughout the second.
- R7: In mode 1, `phase_teacher` and `clamp_out` stay 0, and `noise_en` is the only strobe raised.
- R8: In mode 2, `phase_teacher` is 1 in both phases and `clamp_out` stays 0.
- R9: In mode 3, `load_en` is 1 for all five cycles and `phase_teacher` and `clamp_out` stay 0. `load_en` is 0 in every other mode and when idle.
- R10: With `decay_period`=N>0, `decay_pulse` is 1 together with `done` on every Nth completed mode-2 presentation. Presentations in other modes do not advance the count. With N=0 it is never raised.
- R11: After reset, every strobe, `done`, `busy`, `decay_pulse` and `pat_hold` are 0 and `pat_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Presentation mode, sampled at acceptance |
| decay_period | input | DECAY_W | Unsupervised presentations per decay pulse, 0 disables |
| pat_valid | input | 1 | Pattern offered |
| pat_ready | output | 1 | Sequencer idle and able to accept |
| pat_data | input | PAT_W | Offered pattern |
| pat_hold | output | PAT_W | Captured pattern driven to the clamped neurons |
| busy | output | 1 | Presentation in progress |
| noise_en | output | 1 | Noise burst enable |
| corr_strobe | output | 1 | Correlation count strobe |
| adjust_strobe | output | 1 | Weight update strobe |
| phase_teacher | output | 1 | 1 = teacher phase, 0 = student phase |
| clamp_out | output | 1 | Clamp output neurons to the pattern |
| load_en | output | 1 | Weight shift-in enable |
| done | output | 1 | Last cycle of the presentation |
| decay_pulse | output | 1 | Weight decay request |

## Verification
The assertions assume three things about the inputs:
- Reset is held for at least one clock edge before any other activity.
- The source obeys the handshake, so a pattern only enters while the sequencer is idle.
- `decay_period` changes only between presentations.

The stimulus changes inputs only on falling edges. It changes `decay_period` only while idle. It deliberately keeps `pat_valid` high, and alters `pat_data` and `mode`, while a presentation runs, to show that those inputs are ignored rather than that they are avoided. The ordering of the strobes (noise, then count two cycles before adjust) is checked only as it appears in presentations started from reset.

// File: rtl/present_seq_pkg.sv
package present_seq_pkg;

  typedef enum logic [1:0] {
    MODE_LEARN = 2'd0,
    MODE_TEST  = 2'd1,
    MODE_UNSUP = 2'd2,
    MODE_LOAD  = 2'd3
  } pres_mode_e;

  // subphase slots (0-based) of the per-phase strobes
  localparam int unsigned SLOT_NOISE  = 0;
  localparam int unsigned SLOT_COUNT  = 1;
  localparam int unsigned SLOT_ADJUST = 3;

  function automatic logic mode_is_paired(pres_mode_e m);
    return (m == MODE_LEARN) || (m == MODE_UNSUP);
  endfunction

  function automatic logic mode_has_noise(pres_mode_e m);
    return m != MODE_LOAD;
  endfunction

endpackage

// File: rtl/seq_frame_timer.sv
module seq_frame_timer #(
  parameter int unsigned SUBS = 5,
  localparam int unsigned SW = (SUBS > 1) ? $clog2(SUBS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          paired,
  output logic          busy,
  output logic [SW-1:0] sub,
  output logic          phase_idx,
  output logic          last_cycle
);

  logic last_sub;
  logic last_phase;

  assign last_sub   = (sub == SW'(SUBS - 1));
  assign last_phase = paired ? phase_idx : 1'b1;
  assign last_cycle = busy && last_sub && last_phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      sub       <= '0;
      phase_idx <= 1'b0;
    end else if (launch) begin
      busy      <= 1'b1;
      sub       <= '0;
      phase_idx <= 1'b0;
    end else if (busy) begin
      if (last_sub) begin
        sub <= '0;
        if (last_phase) begin
          busy      <= 1'b0;
          phase_idx <= 1'b0;
        end else begin
          phase_idx <= 1'b1;
        end
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

endmodule

// File: rtl/seq_strobe_decode.sv
module seq_strobe_decode
  import present_seq_pkg::*;
#(
  parameter int unsigned SUBS = 5,
  localparam int unsigned SW = (SUBS > 1) ? $clog2(SUBS) : 1
) (
  input  logic          busy,
  input  pres_mode_e    mode,
  input  logic [SW-1:0] sub,
  input  logic          phase_idx,
  output logic          noise_en,
  output logic          corr_strobe,
  output logic          adjust_strobe,
  output logic          phase_teacher,
  output logic          clamp_out,
  output logic          load_en
);

  logic in_noise, in_count, in_adjust;

  assign in_noise  = (sub == SW'(SLOT_NOISE));
  assign in_count  = (sub == SW'(SLOT_COUNT));
  assign in_adjust = (sub == SW'(SLOT_ADJUST));

  always_comb begin
    noise_en      = busy && in_noise && mode_has_noise(mode);
    corr_strobe   = busy && in_count && mode_is_paired(mode);
    adjust_strobe = busy && in_adjust && phase_idx && mode_is_paired(mode);
    load_en       = busy && (mode == MODE_LOAD);
    phase_teacher = 1'b0;
    clamp_out     = 1'b0;
    if (busy) begin
      unique case (mode)
        MODE_LEARN: begin
          phase_teacher = !phase_idx;
          clamp_out     = !phase_idx;
        end
        MODE_UNSUP: phase_teacher = 1'b1;
        default: begin
          phase_teacher = 1'b0;
          clamp_out     = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/seq_decay_timer.sv
module seq_decay_timer #(
  parameter int unsigned DECAY_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [DECAY_W-1:0] period,
  output logic               pulse
);

  logic [DECAY_W-1:0] seen;
  logic [DECAY_W:0]   next_seen;
  logic               enabled;

  assign enabled   = (period != '0);
  assign next_seen = {1'b0, seen} + 1'b1;
  assign pulse     = tick && enabled && (next_seen >= {1'b0, period});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= '0;
    end else if (tick) begin
      if (!enabled || pulse) seen <= '0;
      else                   seen <= next_seen[DECAY_W-1:0];
    end
  end

endmodule

// File: rtl/present_seq.sv
module present_seq
  import present_seq_pkg::*;
#(
  parameter int unsigned PAT_W   = 8,
  parameter int unsigned SUBS    = 5,
  parameter int unsigned DECAY_W = 8,
  localparam int unsigned SW = (SUBS > 1) ? $clog2(SUBS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode,
  input  logic [DECAY_W-1:0] decay_period,
  input  logic               pat_valid,
  output logic               pat_ready,
  input  logic [PAT_W-1:0]   pat_data,
  output logic [PAT_W-1:0]   pat_hold,
  output logic               busy,
  output logic               noise_en,
  output logic               corr_strobe,
  output logic               adjust_strobe,
  output logic               phase_teacher,
  output logic               clamp_out,
  output logic               load_en,
  output logic               done,
  output logic               decay_pulse
);

  pres_mode_e    mode_q;
  logic          launch;
  logic [SW-1:0] sub;
  logic          phase_idx;
  logic          last_cycle;

  assign pat_ready = !busy;
  assign launch    = pat_valid && pat_ready;
  assign done      = last_cycle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= MODE_LEARN;
      pat_hold <= '0;
    end else if (launch) begin
      mode_q   <= pres_mode_e'(mode);
      pat_hold <= pat_data;
    end
  end

  seq_frame_timer #(.SUBS(SUBS)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .paired     (mode_is_paired(mode_q)),
    .busy       (busy),
    .sub        (sub),
    .phase_idx  (phase_idx),
    .last_cycle (last_cycle)
  );

  seq_strobe_decode #(.SUBS(SUBS)) u_decode (
    .busy          (busy),
    .mode          (mode_q),
    .sub           (sub),
    .phase_idx     (phase_idx),
    .noise_en      (noise_en),
    .corr_strobe   (corr_strobe),
    .adjust_strobe (adjust_strobe),
    .phase_teacher (phase_teacher),
    .clamp_out     (clamp_out),
    .load_en       (load_en)
  );

  seq_decay_timer #(.DECAY_W(DECAY_W)) u_decay (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (last_cycle && (mode_q == MODE_UNSUP)),
    .period (decay_period),
    .pulse  (decay_pulse)
  );

endmodule

// File: rtl/present_seq_chk.sv
module present_seq_chk #(
  parameter int unsigned PAT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pat_ready,
  input logic [PAT_W-1:0] pat_hold,
  input logic             busy,
  input logic             noise_en,
  input logic             corr_strobe,
  input logic             adjust_strobe,
  input logic             load_en,
  input logic             done,
  input logic             decay_pulse
);

  p_hold_steady_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(pat_hold));

  p_ready_after_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> pat_ready);

  p_count_after_noise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    corr_strobe |-> $past(noise_en));

  p_adjust_after_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adjust_strobe |-> $past(corr_strobe, 2));

  p_strobes_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({noise_en, corr_strobe, adjust_strobe}));

  p_load_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> !(noise_en || corr_strobe || adjust_strobe));

  p_decay_on_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    decay_pulse |-> done);

endmodule

bind present_seq present_seq_chk #(.PAT_W(PAT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pat_ready     (pat_ready),
  .pat_hold      (pat_hold),
  .busy          (busy),
  .noise_en      (noise_en),
  .corr_strobe   (corr_strobe),
  .adjust_strobe (adjust_strobe),
  .load_en       (load_en),
  .done          (done),
  .decay_pulse   (decay_pulse)
);

// File: tb/present_seq_test.sv
`timescale 1ns/1ps
module present_seq_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic [7:0] decay_period = 8'd0;
  logic       pat_valid = 1'b0;
  logic       pat_ready;
  logic [7:0] pat_data = 8'd0;
  logic [7:0] pat_hold;
  logic busy, noise_en, corr_strobe, adjust_strobe, phase_teacher;
  logic clamp_out, load_en, done, decay_pulse;

  int  n_tests = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  present_seq uut (
    .clk(clk), .rst_n(rst_n), .mode(mode_i), .decay_period(decay_period),
    .pat_valid(pat_valid), .pat_ready(pat_ready), .pat_data(pat_data),
    .pat_hold(pat_hold), .busy(busy), .noise_en(noise_en),
    .corr_strobe(corr_strobe), .adjust_strobe(adjust_strobe),
    .phase_teacher(phase_teacher), .clamp_out(clamp_out), .load_en(load_en),
    .done(done), .decay_pulse(decay_pulse)
  );

  // {mode[1:0], pattern[7:0], expected length[3:0]}
  localparam logic [13:0] VEC [8] = '{
    {2'd0, 8'hA5, 4'd10}, {2'd1, 8'h3C, 4'd5}, {2'd2, 8'h0F, 4'd10},
    {2'd3, 8'h81, 4'd5},  {2'd0, 8'hFF, 4'd10}, {2'd2, 8'h00, 4'd10},
    {2'd1, 8'h7E, 4'd5},  {2'd3, 8'h5A, 4'd5}
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp,
                     input string tag, input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // check one cycle c of a presentation against the requirement rules
  task automatic check_cycle(input logic [1:0] m, input logic [7:0] pat,
                             input int c, input int len, input bit exp_decay);
    int ph = c / 5;
    int s = c % 5;
    bit paired = (m == 2'd0) || (m == 2'd2);
    string mt = (m == 2'd0) ? "R6" : (m == 2'd1) ? "R7" : (m == 2'd2) ? "R8" : "R9";
    chk(pat_hold, pat, "R1", "pat_hold held");
    chk(pat_ready, 0, "R1", "ready while busy");
    chk(noise_en, (m != 2'd3) && s == 0, "R3", "noise_en");
    chk(corr_strobe, paired && s == 1, "R4", "corr_strobe");
    chk(adjust_strobe, paired && ph == 1 && s == 3, "R5", "adjust_strobe");
    chk(phase_teacher, (m == 2'd0) ? (ph == 0) : (m == 2'd2), mt, "phase_teacher");
    chk(clamp_out, (m == 2'd0) && ph == 0, mt, "clamp_out");
    chk(load_en, m == 2'd3, "R9", "load_en");
    chk(done, c == len - 1, "R2", "done");
    chk(decay_pulse, exp_decay && (c == len - 1), "R10", "decay_pulse");
  endtask

  task automatic present(input logic [1:0] m, input logic [7:0] pat,
                         input int len, input bit exp_decay);
    @(negedge clk);
    mode_i = m; pat_data = pat; pat_valid = 1'b1;
    chk(pat_ready, 1, "R1", "ready before accept");
    @(negedge clk);
    pat_valid = 1'b0; pat_data = ~pat; mode_i = ~m;
    for (int c = 0; c < len; c++) begin
      if (c > 0) @(negedge clk);
      check_cycle(m, pat, c, len, exp_decay);
    end
    @(negedge clk);
    chk(pat_ready, 1, "R2", "ready after done");
    chk(done, 0, "R2", "done cleared");
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(pat_ready, 1, "R11", "ready in reset");
    chk({busy, noise_en, corr_strobe, adjust_strobe, phase_teacher, clamp_out, load_en, done},
        0, "R11", "controls in reset");
    chk(decay_pulse, 0, "R11", "decay in reset");
    chk(pat_hold, 0, "R11", "pat_hold in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(pat_ready, 1, "R11", "ready after reset");
    chk(busy, 0, "R11", "idle after reset");

    // table walk, decay disabled (R10 expects no pulse)
    foreach (VEC[i])
      present(VEC[i][13:12], VEC[i][11:4], int'(VEC[i][3:0]), 1'b0);

    // R1: valid held with new data and mode during a presentation is ignored
    @(negedge clk);
    mode_i = 2'd0; pat_data = 8'hC3; pat_valid = 1'b1;
    @(negedge clk);
    pat_data = 8'h99; mode_i = 2'd1;
    for (int c = 0; c < 10; c++) begin
      if (c > 0) @(negedge clk);
      check_cycle(2'd0, 8'hC3, c, 10, 1'b0);
    end
    @(negedge clk);
    chk(pat_ready, 1, "R1", "ready with valid held");
    @(negedge clk);
    pat_valid = 1'b0;
    check_cycle(2'd1, 8'h99, 0, 5, 1'b0);
    for (int c = 1; c < 5; c++) begin
      @(negedge clk);
      check_cycle(2'd1, 8'h99, c, 5, 1'b0);
    end
    @(negedge clk);
    chk(pat_ready, 1, "R2", "ready after test frame");

    // R10: decay every third unsupervised presentation
    decay_period = 8'd3;
    present(2'd2, 8'h11, 10, 1'b0);
    present(2'd2, 8'h22, 10, 1'b0);
    present(2'd2, 8'h33, 10, 1'b1);
    present(2'd0, 8'h44, 10, 1'b0);
    present(2'd2, 8'h55, 10, 1'b0);
    present(2'd2, 8'h66, 10, 1'b0);
    present(2'd2, 8'h77, 10, 1'b1);
    decay_period = 8'd0;
    present(2'd2, 8'h88, 10, 1'b0);
    present(2'd2, 8'h99, 10, 1'b0);
    present(2'd2, 8'hAA, 10, 1'b0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule